// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 32-bit operand address for the memory addressing modes of a processor that keeps separate data and address register files. Each cycle it may accept one request. A request carries a mode code, an operand size, the selected address register (its number and current value), an index register value, the program counter and up to two extension words. One clock later the block presents the effective address and a copy of that address cut down to the narrower external bus. For the increment and decrement modes it also presents the updated address register value, with a write enable for the register file.

All address arithmetic is a full 32 bits wide and runs on adders inside this block, separate from any data ALU. Sums wrap modulo 2^32. Only the external bus copy is truncated. Instruction decode, bus sequencing and the register file itself sit outside the block.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `valid_out`, `areg_wr`, `ea`, `bus_addr` and `areg_new` all at zero.
- R2: Each request accepted with `valid_in` high produces exactly one result with `valid_out` high on the following clock edge. A cycle without `valid_in` gives `valid_out` low one edge later.
- R3: Mode 0 (register indirect) gives `ea` equal to the address register value and leaves `areg_wr` low.
- R4: Mode 1 (post-increment) gives `ea` equal to the old register value, `areg_new` equal to that value plus the step, and `areg_wr` high.
- R5: Mode 2 (pre-decrement) gives `areg_new` equal to the register value minus the step, `ea` equal to `areg_new`, and `areg_wr` high.
- R6: The step is 1 for size 0 (byte), 2 for size 1 (word) and 4 for sizes 2 and 3 (long). When `areg_num` is 7 and the size is byte, the step is 2.
- R7: Mode 3 adds the sign-extended 16-bit `ext_hi` to the address register.
- R8: Mode 4 adds the address register, the sign-extended `ext_hi[7:0]` and the index. The index is `idx_val` unchanged when `idx_long` is 1, and the sign-extended `idx_val[15:0]` when `idx_long` is 0.
- R9: Mode 5 adds the sign-extended 16-bit `ext_hi` to `pc`. Mode 6 adds `pc`, the sign-extended `ext_hi[7:0]` and the index formed as in R8.
- R10: Mode 7 gives `ea` as the sign-extended `ext_hi`. Mode 8 gives `ea` as `{ext_hi, ext_lo}`.
- R11: All sums wrap modulo 2^32. `bus_addr` equals `ea[23:0]`.
- R12: `areg_wr` is high only for accepted mode 1 or mode 2 requests. Mode codes 9 to 15 give `ea` of zero with `areg_wr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode code |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| areg_num | input | 3 | Number of the selected address register |
| areg_val | input | 32 | Value of the selected address register |
| idx_val | input | 32 | Index register value |
| idx_long | input | 1 | 1 uses all 32 index bits, 0 the sign-extended low 16 |
| pc | input | 32 | Program counter for relative modes |
| ext_hi | input | 16 | First extension word: displacement, short address or high half |
| ext_lo | input | 16 | Second extension word: low half of a long address |
| valid_out | output | 1 | Result present |
| ea | output | 32 | Effective address |
| bus_addr | output | 24 | Effective address truncated to the external bus |
| areg_new | output | 32 | Updated address register value |
| areg_wr | output | 1 | Write-back enable for `areg_new` |
| areg_num_out | output | 3 | Register number to be written back |

## Verification
The only state in the block is the single output stage, so any fault shows up at the ports on the edge after the request that exposes it. A wrong step, a sign extension taken from the wrong bit, or a carry lost above bit 23 gives a wrong `ea` or `areg_new` in that same result. A stuck or stale write enable shows as `areg_wr` high beside a non-updating mode, or as a missing update after an increment. The stimulus therefore pairs each mode with values that cross sign and wrap boundaries: stack-pointer byte steps, decrement below zero, negative index halves with non-zero upper bits, and displacements that carry out of bit 31.

// File: rtl/ea_pkg.sv
// Package: shared mode and size codes for the effective address generator.
// Assumes the mode field is four bits and the size field two bits.
package ea_pkg;
    typedef enum logic [3:0] {
        EA_IND  = 4'd0,
        EA_POST = 4'd1,
        EA_PRE  = 4'd2,
        EA_DISP = 4'd3,
        EA_IDX  = 4'd4,
        EA_PCD  = 4'd5,
        EA_PCX  = 4'd6,
        EA_ABSW = 4'd7,
        EA_ABSL = 4'd8
    } ea_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } ea_size_e;
endpackage

// File: rtl/eag_step.sv
// Module: eag_step
// Produces the register step for increment/decrement modes from the operand
// size (R6). A byte step on the stack register is widened to two so the stack
// stays word aligned. Purely combinational.
module eag_step #(
    parameter int AW     = 32,
    parameter int SEL_W  = 3,
    parameter int SP_NUM = 7
) (
    input  logic [1:0]       size,
    input  logic [SEL_W-1:0] reg_num,
    output logic [AW-1:0]    step
);
    import ea_pkg::*;

    logic is_sp;

    // Detect the stack register.
    always_comb is_sp = (reg_num == SEL_W'(SP_NUM));

    // Select step by operand size (R6).
    always_comb begin
        unique case (ea_size_e'(size))
            SZ_BYTE: step = is_sp ? AW'(2) : AW'(1);
            SZ_WORD: step = AW'(2);
            default: step = AW'(4);
        endcase
    end
endmodule

// File: rtl/eag_index.sv
// Module: eag_index
// Forms the index term for indexed modes (R8, R9): either the whole register
// or its low half sign-extended. Assumes SHORT_W < AW.
module eag_index #(
    parameter int AW      = 32,
    parameter int SHORT_W = 16
) (
    input  logic [AW-1:0] idx_val,
    input  logic          idx_long,
    output logic [AW-1:0] idx_term
);
    logic [AW-1:0] idx_short;

    // Sign-extend the low part of the index.
    always_comb idx_short = {{(AW-SHORT_W){idx_val[SHORT_W-1]}}, idx_val[SHORT_W-1:0]};

    // Choose long or short index.
    always_comb idx_term = idx_long ? idx_val : idx_short;
endmodule

// File: rtl/eag_adder.sv
// Module: eag_adder
// Three-operand address adder of width AW, wrapping modulo 2^AW (R11).
// Dedicated to address arithmetic; carries beyond AW are discarded.
module eag_adder #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] off_a,
    input  logic [AW-1:0] off_b,
    output logic [AW-1:0] sum
);
    // Sum three terms at full width.
    always_comb sum = base + off_a + off_b;
endmodule

// File: rtl/ea_gen.sv
// Module: ea_gen (top)
// Computes the effective address for the memory addressing modes and the
// write-back value of the address register for increment/decrement modes.
// One request per cycle; results appear one clock edge later.
// Assumes extension words are already fetched and presented with the request.
module ea_gen #(
    parameter int AW     = 32,
    parameter int BUS_W  = 24,
    parameter int SEL_W  = 3,
    parameter int SP_NUM = 7,
    parameter int DISP_W = 16,
    parameter int D8_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [3:0]       mode,
    input  logic [1:0]       size,
    input  logic [SEL_W-1:0] areg_num,
    input  logic [AW-1:0]    areg_val,
    input  logic [AW-1:0]    idx_val,
    input  logic             idx_long,
    input  logic [AW-1:0]    pc,
    input  logic [DISP_W-1:0] ext_hi,
    input  logic [DISP_W-1:0] ext_lo,
    output logic             valid_out,
    output logic [AW-1:0]    ea,
    output logic [BUS_W-1:0] bus_addr,
    output logic [AW-1:0]    areg_new,
    output logic             areg_wr,
    output logic [SEL_W-1:0] areg_num_out
);
    import ea_pkg::*;

    localparam int LONG_W = 2 * DISP_W;

    logic [AW-1:0] step, idx_term, disp16, disp8, long_abs;
    logic [AW-1:0] base, off_a, off_b, sum_main;
    logic [AW-1:0] step_signed, sum_upd;
    logic [AW-1:0] ea_next;
    logic          is_dec, is_incdec;
    ea_mode_e      mode_e;

    // Interpret the raw mode field.
    always_comb mode_e = ea_mode_e'(mode);

    eag_step #(.AW(AW), .SEL_W(SEL_W), .SP_NUM(SP_NUM)) u_step (
        .size    (size),
        .reg_num (areg_num),
        .step    (step)
    );

    eag_index #(.AW(AW), .SHORT_W(DISP_W)) u_index (
        .idx_val  (idx_val),
        .idx_long (idx_long),
        .idx_term (idx_term)
    );

    // Sign-extend the displacement fields (R7, R8, R9, R10).
    always_comb begin
        disp16 = {{(AW-DISP_W){ext_hi[DISP_W-1]}}, ext_hi};
        disp8  = {{(AW-D8_W){ext_hi[D8_W-1]}}, ext_hi[D8_W-1:0]};
    end

    // Form the long absolute address; generate picks the fit to AW.
    generate
        if (LONG_W >= AW) begin : g_abs_trim
            logic [LONG_W-1:0] abs_cat;
            always_comb abs_cat = {ext_hi, ext_lo};
            always_comb long_abs = abs_cat[AW-1:0];
        end else begin : g_abs_pad
            always_comb long_abs = {{(AW-LONG_W){1'b0}}, ext_hi, ext_lo};
        end
    endgenerate

    // Classify increment/decrement modes (R4, R5, R12).
    always_comb begin
        is_dec    = (mode_e == EA_PRE);
        is_incdec = (mode_e == EA_POST) || (mode_e == EA_PRE);
    end

    // Pick adder operands per mode (R3, R7-R10, R12).
    always_comb begin
        base  = '0;
        off_a = '0;
        off_b = '0;
        unique case (mode_e)
            EA_IND, EA_POST: base = areg_val;
            EA_DISP: begin base = areg_val; off_a = disp16; end
            EA_IDX:  begin base = areg_val; off_a = disp8; off_b = idx_term; end
            EA_PCD:  begin base = pc;       off_a = disp16; end
            EA_PCX:  begin base = pc;       off_a = disp8; off_b = idx_term; end
            EA_ABSW: off_a = disp16;
            EA_ABSL: base = long_abs;
            default: base = '0;
        endcase
    end

    eag_adder #(.AW(AW)) u_main_add (
        .base  (base),
        .off_a (off_a),
        .off_b (off_b),
        .sum   (sum_main)
    );

    // Signed step: subtract for pre-decrement (R5).
    always_comb step_signed = is_dec ? (~step + AW'(1)) : step;

    eag_adder #(.AW(AW)) u_upd_add (
        .base  (areg_val),
        .off_a (step_signed),
        .off_b ('0),
        .sum   (sum_upd)
    );

    // Pre-decrement addresses with the updated value (R5).
    always_comb ea_next = is_dec ? sum_upd : sum_main;

    // Output stage with synchronous active-low reset (R1, R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out    <= 1'b0;
            areg_wr      <= 1'b0;
            ea           <= '0;
            bus_addr     <= '0;
            areg_new     <= '0;
            areg_num_out <= '0;
        end else begin
            valid_out <= valid_in;
            areg_wr   <= valid_in && is_incdec;
            if (valid_in) begin
                ea           <= ea_next;
                bus_addr     <= ea_next[BUS_W-1:0];
                areg_new     <= sum_upd;
                areg_num_out <= areg_num;
            end
        end
    end

    // R2: an accepted request yields a result on the next edge.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    // R2: no request, no result.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    // R12: non-updating modes never write back.
    a_r12_no_wr_other: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !((mode == EA_POST) || (mode == EA_PRE))) |=> !areg_wr);

    // R4: post-increment addresses with the old register value.
    a_r4_post_old: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode == EA_POST) |=> (ea == $past(areg_val)) && areg_wr);

    // R5: pre-decrement addresses with the written-back value.
    a_r5_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode == EA_PRE) |=> (ea == areg_new) && areg_wr);

    // R6: an even stack register stays even after any step.
    a_r6_sp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && ((mode == EA_POST) || (mode == EA_PRE)) &&
         areg_num == SEL_W'(SP_NUM) && !areg_val[0]) |=> !areg_new[0]);

    // R11: the bus copy tracks the low bits of the address.
    a_r11_bus_low: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> bus_addr == ea[BUS_W-1:0]);
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [2:0]  areg_num = '0;
    logic [31:0] areg_val = '0, idx_val = '0, pc = '0;
    logic        idx_long = 1'b0;
    logic [15:0] ext_hi = '0, ext_lo = '0;
    logic        valid_out, areg_wr;
    logic [31:0] ea, areg_new;
    logic [23:0] bus_addr;
    logic [2:0]  areg_num_out;

    int total = 0, bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] ea;
        logic [31:0] nv;
        logic        wr;
        logic [2:0]  rn;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    ea_gen u_ea_gen (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode(mode), .size(size),
        .areg_num(areg_num), .areg_val(areg_val), .idx_val(idx_val),
        .idx_long(idx_long), .pc(pc), .ext_hi(ext_hi), .ext_lo(ext_lo),
        .valid_out(valid_out), .ea(ea), .bus_addr(bus_addr), .areg_new(areg_new),
        .areg_wr(areg_wr), .areg_num_out(areg_num_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference model from the requirements (R3-R12).
    function automatic exp_t model(input logic [3:0] m, input logic [1:0] sz,
                                   input logic [2:0] rn, input logic [31:0] a,
                                   input logic [31:0] x, input logic xl,
                                   input logic [31:0] p, input logic [15:0] h,
                                   input logic [15:0] l, input string tag);
        exp_t e;
        logic [31:0] st, ix, d16, d8;
        st  = (sz == 2'd0) ? ((rn == 3'd7) ? 32'd2 : 32'd1) : (sz == 2'd1) ? 32'd2 : 32'd4;
        ix  = xl ? x : {{16{x[15]}}, x[15:0]};
        d16 = {{16{h[15]}}, h};
        d8  = {{24{h[7]}}, h[7:0]};
        e.wr = 1'b0; e.nv = 32'h0; e.rn = rn; e.tag = tag;
        case (m)
            4'd0: e.ea = a;
            4'd1: begin e.ea = a; e.nv = a + st; e.wr = 1'b1; end
            4'd2: begin e.nv = a - st; e.ea = e.nv; e.wr = 1'b1; end
            4'd3: e.ea = a + d16;
            4'd4: e.ea = a + d8 + ix;
            4'd5: e.ea = p + d16;
            4'd6: e.ea = p + d8 + ix;
            4'd7: e.ea = d16;
            4'd8: e.ea = {h, l};
            default: e.ea = 32'h0;
        endcase
        return e;
    endfunction

    // Driver: apply one request at a falling edge and queue its expectation.
    task automatic send(input logic [3:0] m, input logic [1:0] sz, input logic [2:0] rn,
                        input logic [31:0] a, input logic [31:0] x, input logic xl,
                        input logic [31:0] p, input logic [15:0] h, input logic [15:0] l,
                        input string tag);
        @(negedge clk);
        valid_in = 1'b1; mode = m; size = sz; areg_num = rn; areg_val = a;
        idx_val = x; idx_long = xl; pc = p; ext_hi = h; ext_lo = l;
        q.push_back(model(m, sz, rn, a, x, xl, p, h, l, tag));
    endtask

    // Driver: an idle cycle with garbage on the data inputs.
    task automatic idle();
        @(negedge clk);
        valid_in = 1'b0; mode = 4'd1; size = 2'd2; areg_val = 32'hDEAD_BEEF;
    endtask

    // Monitor: compare each result against the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (valid_out) begin
                    if (q.size() == 0) begin
                        check("R2 unexpected result", 32'(valid_out), 32'h0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check({e.tag, " ea"}, ea, e.ea);
                        check({"R11 bus ", e.tag}, 32'(bus_addr), {8'h0, e.ea[23:0]});
                        check({"R12 wr ", e.tag}, 32'(areg_wr), 32'(e.wr));
                        if (e.wr) begin
                            check({e.tag, " new"}, areg_new, e.nv);
                            check({e.tag, " num"}, 32'(areg_num_out), 32'(e.rn));
                        end
                    end
                end else begin
                    check("R12 idle no write", 32'(areg_wr), 32'h0);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 valid", 32'(valid_out), 32'h0);
        check("R1 wr", 32'(areg_wr), 32'h0);
        check("R1 ea", ea, 32'h0);
        check("R1 bus", 32'(bus_addr), 32'h0);
        check("R1 new", areg_new, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        send(4'd0, 2'd1, 3'd1, 32'h0012_3456, 0, 0, 0, 0, 0, "R3 indirect");
        send(4'd1, 2'd0, 3'd3, 32'h0000_1000, 0, 0, 0, 0, 0, "R4 R6 post byte");
        send(4'd1, 2'd1, 3'd3, 32'h0000_1000, 0, 0, 0, 0, 0, "R4 R6 post word");
        send(4'd1, 2'd2, 3'd4, 32'h0000_1000, 0, 0, 0, 0, 0, "R4 R6 post long");
        send(4'd1, 2'd3, 3'd4, 32'hFFFF_FFFE, 0, 0, 0, 0, 0, "R4 R11 post long wrap");
        send(4'd1, 2'd0, 3'd7, 32'h0000_8000, 0, 0, 0, 0, 0, "R6 sp byte inc");
        send(4'd2, 2'd0, 3'd7, 32'h0000_8000, 0, 0, 0, 0, 0, "R5 R6 sp byte dec");
        idle();
        send(4'd2, 2'd2, 3'd2, 32'h0100_0000, 0, 0, 0, 0, 0, "R5 pre long");
        send(4'd2, 2'd0, 3'd0, 32'h0000_0000, 0, 0, 0, 0, 0, "R5 R11 pre wrap");
        send(4'd3, 2'd1, 3'd5, 32'h0000_2000, 0, 0, 0, 16'hFFF0, 0, "R7 disp neg");
        send(4'd3, 2'd1, 3'd5, 32'hFFFF_FFF0, 0, 0, 0, 16'h0020, 0, "R7 R11 disp wrap");
        send(4'd4, 2'd1, 3'd6, 32'h0000_4000, 32'h1234_FFFE, 0, 0, 16'h7F80, 0, "R8 idx short");
        send(4'd4, 2'd1, 3'd6, 32'h0000_4000, 32'h1234_FFFE, 1, 0, 16'h0010, 0, "R8 idx long");
        idle();
        idle();
        send(4'd5, 2'd1, 3'd1, 0, 0, 0, 32'h00FF_FFF0, 16'h0020, 0, "R9 R11 pc disp carry");
        send(4'd6, 2'd1, 3'd1, 0, 32'h0000_8000, 0, 32'h0000_9000, 16'h00FE, 0, "R9 pc idx");
        send(4'd7, 2'd1, 3'd1, 32'h5555_5555, 0, 0, 0, 16'h8000, 0, "R10 abs short neg");
        send(4'd7, 2'd1, 3'd1, 32'h5555_5555, 0, 0, 0, 16'h7FFE, 0, "R10 abs short pos");
        send(4'd8, 2'd1, 3'd1, 32'h5555_5555, 0, 0, 0, 16'hAB12, 16'h3456, "R10 abs long");
        send(4'd12, 2'd2, 3'd2, 32'h7777_7777, 0, 0, 32'h1111_1111, 16'h1234, 16'h5678, "R12 undefined mode");
        send(4'd15, 2'd0, 3'd7, 32'h7777_7777, 0, 0, 0, 16'h1234, 0, "R12 undefined mode 15");
        idle();
        repeat (3) @(negedge clk);
        check("R2 all results seen", 32'(q.size()), 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule